// File: doc/BRIEF.md
# Per-Word DMA Channel Priority Arbiter

This block decides which of several DMA channels may move the next word over an address-generation unit and bus path that all channels share. Each channel presents a request and a 2-bit priority level; the block answers with a registered one-hot grant. The grant is re-decided at every word boundary, which is the cycle the granted channel pulses `word_done`, and whenever the block is idle.

Among the pending channels, only those at the highest level compete. They take turns one word at a time in ascending channel order, wrapping after the last channel. Each of the four levels keeps its own rotation position. A burst of higher-level work therefore pauses a lower-level rotation rather than restarting it.

The block also compares the level of the channel that holds the grant against a supplied core priority. From that comparison it gives one decision: whether DMA or the core owns the external bus.

Top module: `dma_word_arbiter`

## Requirements
- R1: After reset, `grant` is all zero, `busy` is low and every level's rotation position is channel 0. The first grant at any level goes to the lowest-numbered pending channel at that level.
- R2: `grant` has at most one bit set. A bit is set only for a channel whose `req` was high in the cycle before the grant was loaded.
- R3: `grant` is reloaded only on a clock edge where `busy` is low or `word_done` is high. While busy without `word_done` it holds its value. An idle block with a pending request grants on the next edge.
- R4: Channel c's priority is `chan_prio[2c+1:2c]`. Level 3 (code 11) is the highest and level 0 (code 00) the lowest. At a decision point only pending channels at the highest pending level can win.
- R5: Pending channels at the same winning level are granted one word each in ascending channel order, wrapping from channel NCH-1 to channel 0.
- R6: A higher-level request that appears during a lower-level word does not change `grant` until that word's `word_done`. At the next decision the higher channel wins.
- R7: Each level keeps its own rotation position, which moves to the channel after the last one granted at that level. When higher-level work ends, the lower level resumes from where it stopped.
- R8: A channel whose request drops before a decision is not granted. The decision goes straight to the next eligible channel with no empty cycle.
- R9: `busy` is high exactly when `grant` is nonzero.
- R10: `dma_owns_bus` is low when idle. When busy it is high if the granted channel's level is above `core_prio`, and low if it is below. On equal levels it is high only when `core_wins_tie` is low.
- R11: A `word_done` pulse while idle with no request leaves `grant` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NCH | Per-channel transfer request |
| chan_prio | input | 2*NCH | Per-channel 2-bit priority level, channel c in bits 2c+1:2c |
| word_done | input | 1 | Pulse: the granted channel finished its current word |
| core_prio | input | 2 | Core priority level for external bus access |
| core_wins_tie | input | 1 | When levels are equal, 1 gives the bus to the core |
| grant | output | NCH | Registered one-hot word grant |
| busy | output | 1 | A grant is outstanding |
| dma_owns_bus | output | 1 | DMA, not the core, owns the external bus |

## Verification
The bench builds the block at the default of six channels. Six is enough for the rotation to wrap, for two channels to share a level while others sit above and below it, and for all four level codes to appear at once in random stimulus. Random request, level and word-boundary patterns from a fixed seed run against a bench model that keeps its own per-level rotation positions. This exposes preemption and resumption orders that the directed cases do not list, along with every core-level comparison case including ties under both tie settings.

// File: rtl/dma_word_arbiter.sv
module dma_word_arbiter #(
  parameter int NCH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  input  logic [2*NCH-1:0] chan_prio,
  input  logic             word_done,
  input  logic [1:0]       core_prio,
  input  logic             core_wins_tie,
  output logic [NCH-1:0]   grant,
  output logic             busy,
  output logic             dma_owns_bus
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW:0] NCH_W = (IW+1)'(NCH);
  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  logic [1:0]    lvl [NCH];
  logic [IW-1:0] ptr [4];
  logic [1:0]    top;
  logic          any_req;
  logic [NCH-1:0] pick;
  logic [IW-1:0] pick_idx;
  logic [1:0]    act_lvl;
  logic          decide;

  for (genvar c = 0; c < NCH; c++) begin : g_lvl
    assign lvl[c] = chan_prio[2*c +: 2];
  end

  always_comb begin
    top = 2'd0;
    any_req = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      if (req[c] && lvl[c] >= top) top = lvl[c];
      any_req = any_req | req[c];
    end
  end

  always_comb begin
    logic [IW:0]   j;
    logic [IW-1:0] jn;
    logic          found;
    pick = '0;
    pick_idx = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      j = {1'b0, ptr[top]} + (IW+1)'(k);
      if (j >= NCH_W) j = j - NCH_W;
      jn = j[IW-1:0];
      if (!found && req[jn] && lvl[jn] == top) begin
        found = 1'b1;
        pick[jn] = 1'b1;
        pick_idx = jn;
      end
    end
  end

  assign busy   = |grant;
  assign decide = !busy || word_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= '0;
      for (int l = 0; l < 4; l++) ptr[l] <= '0;
    end else if (decide) begin
      grant <= pick;
      if (any_req) ptr[top] <= (pick_idx == LAST) ? '0 : pick_idx + IW'(1);
    end
  end

  always_comb begin
    act_lvl = 2'd0;
    for (int c = 0; c < NCH; c++)
      if (grant[c]) act_lvl = lvl[c];
  end

  assign dma_owns_bus = busy &&
    ((act_lvl > core_prio) || (act_lvl == core_prio && !core_wins_tie));

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2
  grant_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> ((grant & $past(req)) == grant));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_done) |=> $stable(grant));

  // R10
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_owns_bus |-> busy);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req == '0) |=> (grant == '0));
endmodule

// File: tb/sim_dma_word_arbiter.sv
module sim_dma_word_arbiter;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0;
  logic [2*NCH-1:0] chan_prio = '0;
  logic word_done = 1'b0;
  logic [1:0] core_prio = 2'd0;
  logic core_wins_tie = 1'b0;
  logic [NCH-1:0] grant;
  logic busy, dma_owns_bus;

  int total = 0, bad = 0;
  int m_ptr [4];
  int m_gnt = -1;
  string tag = "R1";

  always #5 clk = ~clk;

  dma_word_arbiter #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .chan_prio(chan_prio),
    .word_done(word_done), .core_prio(core_prio), .core_wins_tie(core_wins_tie),
    .grant(grant), .busy(busy), .dma_owns_bus(dma_owns_bus));

  function automatic int lv(int c);
    return int'(chan_prio[2*c +: 2]);
  endfunction

  function automatic int model_pick();
    int best = -1;
    int who = -1;
    for (int c = 0; c < NCH; c++)
      if (req[c] && lv(c) > best) best = lv(c);
    if (best < 0) return -1;
    for (int d = 0; d < NCH; d++) begin
      int c = (m_ptr[best] + d) % NCH;
      if (who < 0 && req[c] && lv(c) == best) who = c;
    end
    return who;
  endfunction

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [NCH-1:0] eg;
    int eb;
    eg = '0;
    if (m_gnt >= 0) eg[m_gnt] = 1'b1;
    check("grant", int'(grant), int'(eg));
    check("busy R9", int'(busy), int'(m_gnt >= 0));
    if (m_gnt < 0) eb = 0;
    else if (lv(m_gnt) > int'(core_prio)) eb = 1;
    else if (lv(m_gnt) < int'(core_prio)) eb = 0;
    else eb = core_wins_tie ? 0 : 1;
    check("bus R10", int'(dma_owns_bus), eb);
  endtask

  task automatic step(logic [NCH-1:0] r, logic [2*NCH-1:0] p, logic wd);
    int nxt;
    @(negedge clk);
    req = r; chan_prio = p; word_done = wd;
    nxt = m_gnt;
    if (m_gnt < 0 || wd) begin
      nxt = model_pick();
      if (nxt >= 0) m_ptr[lv(nxt)] = (nxt + 1) % NCH;
    end
    @(posedge clk);
    #1;
    m_gnt = nxt;
    compare();
  endtask

  function automatic logic [2*NCH-1:0] all_lvl(logic [1:0] l);
    logic [2*NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[2*c +: 2] = l;
    return v;
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2*NCH-1:0] p;
    int seed;
    for (int l = 0; l < 4; l++) m_ptr[l] = 0;
    seed = $urandom(32'd20240601);
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    check("grant at reset", int'(grant), 0);
    check("busy at reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R11: word_done while idle without requests
    tag = "R11";
    step('0, '0, 1'b1);
    step('0, '0, 1'b1);

    // R1: first grant at level 1 is the lowest pending index
    tag = "R1";
    p = all_lvl(2'd1);
    step(6'b010100, p, 1'b0);
    check("first grant ch2", int'(grant), 4);
    step('0, p, 1'b1);

    // R5: all six at level 2, one word each with wrap
    tag = "R5";
    p = all_lvl(2'd2);
    for (int i = 0; i < 8; i++) step('1, p, 1'b1);
    step('0, p, 1'b1);

    // R6 and R7: level 1 group on 0..2, channel 5 jumps in at level 3
    tag = "R6";
    p = all_lvl(2'd1);
    p[11:10] = 2'd3;
    step(6'b000111, p, 1'b0);
    step(6'b000111, p, 1'b1);
    step(6'b100111, p, 1'b0);
    step(6'b100111, p, 1'b0);
    check("R6 hold low word", int'(grant[5]), 0);
    step(6'b100111, p, 1'b1);
    check("R6 high wins", int'(grant), 32);
    step(6'b100111, p, 1'b1);
    tag = "R7";
    step(6'b000111, p, 1'b1);
    step(6'b000111, p, 1'b1);
    step('0, p, 1'b1);

    // R4: mixed levels, highest wins
    tag = "R4";
    p = {2'd0, 2'd2, 2'd1, 2'd3, 2'd0, 2'd2};
    step(6'b110111, p, 1'b1);
    step(6'b110111, p, 1'b1);
    step(6'b110101, p, 1'b1);
    step(6'b110101, p, 1'b1);
    step('0, p, 1'b1);

    // R8: request drops before the decision
    tag = "R8";
    p = all_lvl(2'd0);
    step(6'b000111, p, 1'b0);
    step(6'b000101, p, 1'b1);
    step('0, p, 1'b1);

    // R10: bus ownership against the core level
    tag = "R10";
    p = all_lvl(2'd2);
    for (int cp = 0; cp < 4; cp++)
      for (int t = 0; t < 2; t++) begin
        core_prio = 2'(cp);
        core_wins_tie = t[0];
        step(6'b001000, p, 1'b0);
      end
    step('0, p, 1'b1);

    // R2 R3: random traffic
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      logic [NCH-1:0] r;
      r = NCH'($urandom);
      if ($urandom % 4 == 0) r = '0;
      for (int c = 0; c < NCH; c++) p[2*c +: 2] = 2'($urandom);
      if ($urandom % 3 != 0) p = chan_prio;
      core_prio = 2'($urandom);
      core_wins_tie = 1'($urandom);
      step(r, p, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule